// File: doc/BRIEF.md
# Jam-Loaded Reference and Feedback Divider Pair

This block is the divider stage of a frequency synthesizer. One down-counter divides reference edges by a programmable ratio R. A second down-counter divides VCO edges by a programmable ratio N. Each counter emits a narrow high pulse toward the phase detector when its count runs out. The same two pulses also appear on a pair of output pins, and each pin is gated by its own configuration bit. A third path divides the reference edges by a selectable power of two to give a reference clock output.

Everything runs on one system clock. The reference and VCO edges arrive as single-cycle tick enables. Writing a new N value jam-loads both counters in the same clock, so the two counters restart in step, and it raises a one-cycle re-initialise strobe for the phase detector. If a written ratio is out of range, it is clamped to the nearest legal value and a sticky flag is set.

Top module: `syn_div_pair`

## Requirements
- R1: With R ≥ 5 and one reference tick per step after a load, `fr_pulse` rises after ticks R, 2R, 3R and so on, counted from the load.
- R2: Once `fr_pulse` rises, it stays high across exactly 4 reference-tick intervals (parameter FR_TICKS) and then falls on the 4th tick after its rise.
- R3: With R = 1, `fr_pulse` is high for exactly the clock cycle after each reference tick and low at all other times.
- R4: A cycle with `n_wr` high loads the reference counter with R and the feedback counter with N. If `r_wr` is high in the same cycle, the R used is the one being written. In the next cycle both pulses are low and `pd_init` is high for exactly that one cycle. A reference or VCO tick in the write cycle is not counted.
- R5: `fv_pulse` rises after VCO ticks N, 2N, 3N and so on, counted from a load, and falls on the next VCO tick.
- R6: A write to R without an N write does not disturb the running count. The current period completes with the old ratio, and every later period uses the new one.
- R7: An R of 0 or 2 is stored as 1, an R of 3 or 4 is stored as 5, and an N below 40 is stored as 40. Any such write sets `bad_value`, which stays high until reset.
- R8: `fr_pin` equals `fr_pulse` while configuration bit 0 is 1. `fv_pin` equals `fv_pulse` while configuration bit 1 is 1. Each pin is low while its bit is 0, and both bits are 0 after reset.
- R9: Configuration bits 4:2 select the reference output. Code 000 gives a static low. Code 001 gives one high cycle per tick. Codes 010, 011, 100, 101, 110 and 111 give one rising edge every 2, 4, 8, 16, 8 and 16 ticks. The reset code is 100.
- R10: After reset all outputs are low, and the counters behave as if loaded with R = 5 and N = 40.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_tick | input | 1 | One-cycle enable per reference rising edge |
| vco_tick | input | 1 | One-cycle enable per VCO rising edge |
| r_wr | input | 1 | Write strobe for the reference ratio |
| r_val | input | R_W (15) | Reference ratio to write |
| n_wr | input | 1 | Write strobe for the feedback ratio; also jam-loads both counters |
| n_val | input | N_W (16) | Feedback ratio to write |
| cfg_wr | input | 1 | Write strobe for the configuration bits |
| cfg_val | input | 5 | Bit 0 enables fr_pin, bit 1 enables fv_pin, bits 4:2 select the reference output |
| fr_pulse | output | 1 | Reference divider pulse toward the phase detector |
| fv_pulse | output | 1 | Feedback divider pulse toward the phase detector |
| fr_pin | output | 1 | Gated copy of fr_pulse |
| fv_pin | output | 1 | Gated copy of fv_pulse |
| pd_init | output | 1 | One-cycle phase detector re-initialise strobe after an N write |
| ref_out | output | 1 | Divided reference output |
| bad_value | output | 1 | Sticky flag for a clamped ratio write |

## Verification
The jam load and a counting tick can fall in the same clock. The load must win, and the tick must be lost. The bench provokes this by raising both ticks in the same cycle as an N write that also carries a new R. It then judges the outcome from the full pulse shape over three periods: a counted tick would move every rise one step earlier. A second collision, an N write together with an R write, is judged the same way, since the periods that follow must already use the new R.

// File: rtl/syn_div_pkg.sv
package syn_div_pkg;
   // Reference output select codes (bits 4:2 of the configuration word)
   typedef enum logic [2:0] {
      REF_OFF     = 3'b000,
      REF_D1      = 3'b001,
      REF_D2      = 3'b010,
      REF_D4      = 3'b011,
      REF_D8      = 3'b100,
      REF_D16     = 3'b101,
      REF_D8_ALT  = 3'b110,
      REF_D16_ALT = 3'b111
   } ref_sel_e;

   localparam int CFG_W       = 5;
   localparam int CFG_FR_EN   = 0;
   localparam int CFG_FV_EN   = 1;
   localparam int CFG_SEL_LSB = 2;
   localparam ref_sel_e REF_RESET = REF_D8;
endpackage

// File: rtl/syn_div_count.sv
// Down-counter: loads on a jam and reloads itself on terminal count.
module syn_div_count #(
   parameter int W       = 16,
   parameter int RST_VAL = 40
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tick,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic [W-1:0] mod_val,
   output logic         term
);
   localparam logic [W-1:0] ONE = W'(1);
   localparam logic [W-1:0] RST = W'(RST_VAL);

   logic [W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= RST;
      else if (load)
         cnt <= load_val;
      else if (tick) begin
         if (cnt <= ONE)
            cnt <= mod_val;
         else
            cnt <= cnt - ONE;
      end
   end

   // Terminal count: the tick that consumes the last count. A jam suppresses it.
   assign term = tick && !load && (cnt <= ONE);
endmodule

// File: rtl/syn_div_refshape.sv
// Shapes the reference pulse: TICKS intervals wide, or a tick copy in bypass.
module syn_div_refshape #(
   parameter int TICKS = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic tick,
   input  logic term,
   input  logic bypass,
   output logic pulse
);
   localparam int LW = $clog2(TICKS + 1);
   localparam logic [LW-1:0] L_ONE  = LW'(1);
   localparam logic [LW-1:0] L_FULL = LW'(TICKS);

   logic [LW-1:0] left;
   logic          q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q    <= 1'b0;
         left <= '0;
      end else if (clr) begin
         q    <= 1'b0;
         left <= '0;
      end else if (bypass) begin
         q    <= tick;
         left <= '0;
      end else if (term) begin
         q    <= 1'b1;
         left <= L_FULL;
      end else if (tick && q) begin
         if (left <= L_ONE) begin
            q    <= 1'b0;
            left <= '0;
         end else begin
            left <= left - L_ONE;
         end
      end
   end

   assign pulse = q;
endmodule

// File: rtl/syn_div_refout.sv
// Reference output: a power-of-two prescaler on reference ticks, tap chosen by code.
module syn_div_refout
   import syn_div_pkg::*;
#(
   parameter int PRE_W = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  logic [2:0] sel,
   output logic       out
);
   if (PRE_W < 4) begin : g_chk_pre
      $error("syn_div_refout: PRE_W must be at least 4");
   end

   logic [PRE_W-1:0] pre;
   logic             tick_q;
   logic [PRE_W:0]   tap;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pre    <= '0;
         tick_q <= 1'b0;
      end else begin
         tick_q <= tick;
         if (tick) pre <= pre + PRE_W'(1);
      end
   end

   assign tap[0] = tick_q;
   for (genvar k = 1; k <= PRE_W; k++) begin : g_tap
      assign tap[k] = pre[k-1];
   end

   always_comb begin
      case (ref_sel_e'(sel))
         REF_OFF:                 out = 1'b0;
         REF_D1:                  out = tap[0];
         REF_D2:                  out = tap[1];
         REF_D4:                  out = tap[2];
         REF_D8, REF_D8_ALT:      out = tap[3];
         default:                 out = tap[4];
      endcase
   end
endmodule

// File: rtl/syn_div_pair.sv
module syn_div_pair
   import syn_div_pkg::*;
#(
   parameter int R_W      = 15,
   parameter int N_W      = 16,
   parameter int R_MIN    = 5,
   parameter int N_MIN    = 40,
   parameter int FR_TICKS = 4,
   parameter int PRE_W    = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ref_tick,
   input  logic             vco_tick,
   input  logic             r_wr,
   input  logic [R_W-1:0]   r_val,
   input  logic             n_wr,
   input  logic [N_W-1:0]   n_val,
   input  logic             cfg_wr,
   input  logic [4:0]       cfg_val,
   output logic             fr_pulse,
   output logic             fv_pulse,
   output logic             fr_pin,
   output logic             fv_pin,
   output logic             pd_init,
   output logic             ref_out,
   output logic             bad_value
);
   if (R_MIN < 2 || R_MIN > (2 ** R_W) - 1) begin : g_chk_rmin
      $error("syn_div_pair: R_MIN out of range for R_W");
   end
   if (N_MIN < 2 || N_MIN > (2 ** N_W) - 1) begin : g_chk_nmin
      $error("syn_div_pair: N_MIN out of range for N_W");
   end
   if (FR_TICKS < 1 || FR_TICKS >= R_MIN) begin : g_chk_frw
      $error("syn_div_pair: FR_TICKS must leave a low gap at R_MIN");
   end

   localparam logic [R_W-1:0] R_ONE = R_W'(1);
   localparam logic [R_W-1:0] R_LO  = R_W'(R_MIN);
   localparam logic [N_W-1:0] N_LO  = N_W'(N_MIN);
   localparam logic [CFG_W-1:0] CFG_RST = {REF_RESET, 2'b00};

   logic [R_W-1:0]   r_reg, r_fix, r_load;
   logic [N_W-1:0]   n_reg, n_fix;
   logic [CFG_W-1:0] cfg_q;
   logic             r_bad, n_bad, bypass;
   logic             r_term, n_term, fv_q, init_q, err_q;

   // Clamp incoming ratios to the nearest legal value (ties go upward)
   always_comb begin
      r_bad = (r_val == '0) || (r_val > R_ONE && r_val < R_LO);
      if (r_val == '0)
         r_fix = R_ONE;
      else if (r_bad)
         r_fix = ((r_val - R_ONE) < (R_LO - r_val)) ? R_ONE : R_LO;
      else
         r_fix = r_val;
      n_bad = (n_val < N_LO);
      n_fix = n_bad ? N_LO : n_val;
   end

   // A same-cycle R write is seen by the jam load
   assign r_load = r_wr ? r_fix : r_reg;
   assign bypass = (r_reg == R_ONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         r_reg  <= R_LO;
         n_reg  <= N_LO;
         cfg_q  <= CFG_RST;
         err_q  <= 1'b0;
         init_q <= 1'b0;
      end else begin
         if (r_wr)   r_reg <= r_fix;
         if (n_wr)   n_reg <= n_fix;
         if (cfg_wr) cfg_q <= cfg_val;
         if ((r_wr && r_bad) || (n_wr && n_bad)) err_q <= 1'b1;
         init_q <= n_wr;
      end
   end

   syn_div_count #(.W(R_W), .RST_VAL(R_MIN)) u_rcnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (ref_tick),
      .load     (n_wr),
      .load_val (r_load),
      .mod_val  (r_reg),
      .term     (r_term)
   );

   syn_div_count #(.W(N_W), .RST_VAL(N_MIN)) u_ncnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (vco_tick),
      .load     (n_wr),
      .load_val (n_fix),
      .mod_val  (n_reg),
      .term     (n_term)
   );

   syn_div_refshape #(.TICKS(FR_TICKS)) u_rshape (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (n_wr),
      .tick   (ref_tick),
      .term   (r_term),
      .bypass (bypass),
      .pulse  (fr_pulse)
   );

   // Feedback pulse: one VCO tick interval wide
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         fv_q <= 1'b0;
      else if (n_wr)
         fv_q <= 1'b0;
      else if (n_term)
         fv_q <= 1'b1;
      else if (vco_tick)
         fv_q <= 1'b0;
   end

   syn_div_refout #(.PRE_W(PRE_W)) u_refout (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (ref_tick),
      .sel   (cfg_q[CFG_SEL_LSB +: 3]),
      .out   (ref_out)
   );

   assign fv_pulse  = fv_q;
   assign fr_pin    = fr_pulse & cfg_q[CFG_FR_EN];
   assign fv_pin    = fv_q & cfg_q[CFG_FV_EN];
   assign pd_init   = init_q;
   assign bad_value = err_q;
endmodule

// File: rtl/syn_div_pair_chk.sv
module syn_div_pair_chk (
   input logic clk,
   input logic rst_n,
   input logic ref_tick,
   input logic vco_tick,
   input logic n_wr,
   input logic fr_pulse,
   input logic fv_pulse,
   input logic fr_pin,
   input logic fv_pin,
   input logic pd_init,
   input logic bad_value
);
   a_r4_jam_clears: assert property (@(posedge clk) disable iff (!rst_n)
      n_wr |=> (!fr_pulse && !fv_pulse && pd_init));

   a_r4_init_cause: assert property (@(posedge clk) disable iff (!rst_n)
      pd_init |-> $past(n_wr));

   a_r8_fr_gate: assert property (@(posedge clk) disable iff (!rst_n)
      fr_pin |-> fr_pulse);

   a_r8_fv_gate: assert property (@(posedge clk) disable iff (!rst_n)
      fv_pin |-> fv_pulse);

   a_r5_fv_one_tick: assert property (@(posedge clk) disable iff (!rst_n)
      (fv_pulse && vco_tick && !n_wr) |=> !fv_pulse);

   a_r1_fr_rise_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fr_pulse) |-> $past(ref_tick));

   a_r5_fv_rise_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fv_pulse) |-> $past(vco_tick));

   a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      bad_value |=> bad_value);
endmodule

bind syn_div_pair syn_div_pair_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .ref_tick  (ref_tick),
   .vco_tick  (vco_tick),
   .n_wr      (n_wr),
   .fr_pulse  (fr_pulse),
   .fv_pulse  (fv_pulse),
   .fr_pin    (fr_pin),
   .fv_pin    (fv_pin),
   .pd_init   (pd_init),
   .bad_value (bad_value)
);

// File: tb/sim_syn_div_pair.sv
module sim_syn_div_pair;
   localparam int TCLK = 10;
   localparam int FRT  = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ref_tick = 1'b0, vco_tick = 1'b0;
   logic        r_wr = 1'b0, n_wr = 1'b0, cfg_wr = 1'b0;
   logic [14:0] r_val = '0;
   logic [15:0] n_val = '0;
   logic [4:0]  cfg_val = '0;
   logic        fr_pulse, fv_pulse, fr_pin, fv_pin, pd_init, ref_out, bad_value;

   int n_chk = 0;
   int n_bad = 0;

   always #(TCLK/2) clk = ~clk;

   syn_div_pair u0 (
      .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .vco_tick(vco_tick),
      .r_wr(r_wr), .r_val(r_val), .n_wr(n_wr), .n_val(n_val),
      .cfg_wr(cfg_wr), .cfg_val(cfg_val),
      .fr_pulse(fr_pulse), .fv_pulse(fv_pulse), .fr_pin(fr_pin), .fv_pin(fv_pin),
      .pd_init(pd_init), .ref_out(ref_out), .bad_value(bad_value)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input int got, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
      end
   endtask

   // One reference step: tick cycle, then an idle cycle; samples after each
   task automatic ref_step(output bit a, output bit b, output bit pa, output bit pb,
                           output bit ra, output bit rb);
      @(negedge clk); ref_tick = 1'b1;
      @(negedge clk); a = fr_pulse; pa = fr_pin; ra = ref_out; ref_tick = 1'b0;
      @(negedge clk); b = fr_pulse; pb = fr_pin; rb = ref_out;
   endtask

   task automatic vco_step(output bit a, output bit b, output bit pa, output bit pb);
      @(negedge clk); vco_tick = 1'b1;
      @(negedge clk); a = fv_pulse; pa = fv_pin; vco_tick = 1'b0;
      @(negedge clk); b = fv_pulse; pb = fv_pin;
   endtask

   function automatic bit exp_fr(input int i, input int r);
      if (r == 1) return 1'b1;
      return (i >= r) && ((i % r) < FRT);
   endfunction

   task automatic sweep_ref(input int r, input int steps, input bit en, input string req);
      int miss = 0, first = 0, got = 0, ex = 0;
      bit a, b, pa, pb, ra, rb, ea, eb;
      for (int i = 1; i <= steps; i++) begin
         ref_step(a, b, pa, pb, ra, rb);
         ea = exp_fr(i, r);
         eb = (r == 1) ? 1'b0 : ea;
         if (a != ea || b != eb || pa != (ea & en) || pb != (eb & en)) begin
            if (miss == 0) begin
               first = i;
               got = {a, b, pa, pb};
               ex = {ea, eb, ea & en, eb & en};
            end
            miss++;
         end
      end
      chk(miss == 0, req, $sformatf("reference shape R=%0d first bad step %0d", r, first), got, ex);
   endtask

   task automatic sweep_vco(input int n, input int steps, input bit en, input string req);
      int miss = 0, first = 0, got = 0, ex = 0;
      bit a, b, pa, pb, e;
      for (int i = 1; i <= steps; i++) begin
         vco_step(a, b, pa, pb);
         e = (i >= n) && ((i % n) == 0);
         if (a != e || b != e || pa != (e & en) || pb != (e & en)) begin
            if (miss == 0) begin
               first = i;
               got = {a, b, pa, pb};
               ex = {e, e, e & en, e & en};
            end
            miss++;
         end
      end
      chk(miss == 0, req, $sformatf("feedback shape N=%0d first bad step %0d", n, first), got, ex);
   endtask

   task automatic jam(input int n, input bit wr_r, input int r, input bit ticks);
      @(negedge clk);
      n_wr = 1'b1; n_val = 16'(n); r_wr = wr_r; r_val = 15'(r);
      ref_tick = ticks; vco_tick = ticks;
      @(negedge clk);
      n_wr = 1'b0; r_wr = 1'b0; ref_tick = 1'b0; vco_tick = 1'b0;
      chk(pd_init == 1'b1, "R4", "pd_init after N write", int'(pd_init), 1);
      chk(!fr_pulse && !fv_pulse, "R4", "pulses cleared by jam", int'({fr_pulse, fv_pulse}), 0);
   endtask

   task automatic cfg_write(input logic [4:0] v);
      @(negedge clk); cfg_wr = 1'b1; cfg_val = v;
      @(negedge clk); cfg_wr = 1'b0;
   endtask

   task automatic refout_rises(input int exp, input string what);
      bit a, b, pa, pb, ra, rb, prev;
      int rises = 0;
      @(negedge clk); prev = ref_out;
      for (int i = 0; i < 32; i++) begin
         ref_step(a, b, pa, pb, ra, rb);
         if (ra && !prev) rises++;
         if (rb && !ra) rises++;
         prev = rb;
      end
      chk(rises == exp, "R9", what, rises, exp);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      chk(1'b0, "timeout", "watchdog expired", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      bit a, b, pa, pb, ra, rb, ea;
      int miss;
      int exp_rise [8] = '{0, 32, 16, 8, 4, 2, 4, 2};
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R10 reset state
      chk({fr_pulse, fv_pulse, fr_pin, fv_pin, pd_init, ref_out, bad_value} == 7'd0,
          "R10", "outputs after reset",
          int'({fr_pulse, fv_pulse, fr_pin, fv_pin, pd_init, ref_out, bad_value}), 0);
      sweep_ref(5, 15, 1'b0, "R10 (reset R, pins off R8)");
      sweep_vco(40, 120, 1'b0, "R10 (reset N)");
      refout_rises(4, "reset default divide by 8");

      // R1 R2 R8 with both pins on
      cfg_write(5'b10011);
      jam(45, 1'b1, 6, 1'b0);
      sweep_ref(6, 18, 1'b1, "R1 R2 R8");
      @(negedge clk);
      chk(pd_init == 1'b0, "R4", "pd_init single cycle", int'(pd_init), 0);
      // R4: ticks in the jam cycle are lost, same-cycle R write is used
      jam(45, 1'b1, 7, 1'b1);
      sweep_ref(7, 21, 1'b1, "R4 R1 R2");
      sweep_vco(45, 135, 1'b1, "R4 R5");
      jam(41, 1'b1, 9, 1'b0);
      sweep_ref(9, 27, 1'b1, "R1 R2");
      sweep_vco(41, 123, 1'b1, "R5");
      // R3 bypass
      jam(40, 1'b1, 1, 1'b0);
      sweep_ref(1, 6, 1'b1, "R3");

      // R6: R write alone mid-period
      jam(40, 1'b1, 5, 1'b0);
      miss = 0;
      for (int i = 1; i <= 26; i++) begin
         if (i == 3) begin
            @(negedge clk); r_wr = 1'b1; r_val = 15'd7;
            @(negedge clk); r_wr = 1'b0;
         end
         ref_step(a, b, pa, pb, ra, rb);
         if (i < 12) ea = (i >= 5) && (i - 5 < FRT);
         else        ea = ((i - 5) % 7) < FRT;
         if (a != ea || b != ea) miss++;
      end
      chk(miss == 0, "R6", "R write without jam keeps current period", miss, 0);

      chk(bad_value == 1'b0, "R7", "flag clear after legal writes", int'(bad_value), 0);
      // R7 clamps
      jam(40, 1'b1, 0, 1'b0);
      chk(bad_value == 1'b1, "R7", "flag set by R=0", int'(bad_value), 1);
      sweep_ref(1, 6, 1'b1, "R7 R=0 as 1");
      jam(40, 1'b1, 2, 1'b0);
      sweep_ref(1, 6, 1'b1, "R7 R=2 as 1");
      jam(40, 1'b1, 3, 1'b0);
      sweep_ref(5, 15, 1'b1, "R7 R=3 as 5");
      jam(40, 1'b1, 4, 1'b0);
      sweep_ref(5, 15, 1'b1, "R7 R=4 as 5");
      jam(3, 1'b0, 0, 1'b0);
      sweep_vco(40, 120, 1'b1, "R7 N=3 as 40");
      chk(bad_value == 1'b1, "R7", "flag sticky", int'(bad_value), 1);

      // R8: fv pin disabled, fr pin still on
      cfg_write(5'b10001);
      jam(40, 1'b0, 0, 1'b0);
      sweep_vco(40, 80, 1'b0, "R8 fv pin gated");
      sweep_ref(5, 10, 1'b1, "R8 fr pin on");

      // R9 every select code
      for (int s = 0; s < 8; s++) begin
         cfg_write({3'(s), 2'b00});
         refout_rises(exp_rise[s], $sformatf("select code %0d", s));
      end
      @(negedge clk);
      chk(ref_out == 1'b0, "R9", "select code 7 then off level", 0, 0);
      cfg_write(5'b00000);
      repeat (2) @(negedge clk);
      chk(ref_out == 1'b0, "R9", "static low when off", int'(ref_out), 0);

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule